// File: doc/BRIEF.md
# Sensor Row Video Packetizer

This block sits between a monochrome image sensor and a video link core. It accepts 12-bit pixels one per cycle and packs them back to back, with no padding bits, into 64-bit words. Each completed word goes to the link core's video transmit buffer with a word address and a one-cycle write strobe. One sensor row becomes one video packet: 2048 pixels at 12 bits give 3072 bytes, or exactly 384 words. This is well under the 8192-byte packet limit, and the last word of a row is always full.

When the last word of a row has been written, the block presents the packet header and pulses a send request for one cycle. The header carries a row identifier and a column identifier for the first pixel of the packet. With one lane, the column identifier is always zero. The row identifier can follow plain top-down order, or an interleaved top/bottom order that takes rows alternately from both ends of the frame.

After a send, the block holds off the sensor through a ready signal until the link core reports that its buffer is free again. Frame-start and row-start markers on the pixel stream restart the row numbering and the packing.

Top module: `video_row_packer`

## Requirements
- R1: Within a row, pixel n occupies bits (12·n mod 64) and upward of word ⌊12·n/64⌋, with the pixel's LSB lowest. A pixel that does not fit in the rest of a word continues in the low bits of the next word.
- R2: Every 64 packed bits produce exactly one `buf_we` pulse, in the cycle after the pixel that completes the word is accepted. `buf_waddr` counts 0, 1, … up to ROW_PIX·12/64−1 within a row.
- R3: `send_req` is high for exactly one cycle. That cycle directly follows the write of the row's last word.
- R4: `hdr_col` is 0 whenever `send_req` is high.
- R5: With `split_rd`=0 latched, the row identifiers sent after a frame start are 0, 1, 2, …. After ROWS−1 they wrap to 0.
- R6: With `split_rd`=1 latched, row k of a frame (k counted from 0) is sent with identifier k/2 when k is even and ROWS−1−(k−1)/2 when k is odd, giving 0, ROWS−1, 1, ROWS−2, ….
- R7: `pix_ready` drops in the cycle after the row's last pixel is accepted. It stays low through the send. It rises one cycle after `link_free` is sampled high once the send is done.
- R8: An accepted pixel with `pix_sof` high resets the row counter to 0 and latches `split_rd` as the ordering mode for the frame. `split_rd` has no effect at other times.
- R9: An accepted pixel with `pix_sol` or `pix_sof` high starts a new row. Any partial word is discarded and addresses restart at 0. Without `pix_sof`, the row keeps the identifier of the row it replaces.
- R10: During and right after reset, `pix_ready` is 1 and `buf_we` and `send_req` are 0.
- R11: A pixel offered with `pix_valid` high while `pix_ready` is low is not taken. It produces no write and does not advance the pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_rd | input | 1 | Ordering mode sampled at frame start: 1 = top/bottom interleaved |
| link_free | input | 1 | Link core reports the transmit buffer free |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_sol | input | 1 | Pixel is the first of a row |
| pix_data | input | PIX_W | Pixel value |
| pix_ready | output | 1 | Block takes a valid pixel this cycle |
| buf_we | output | 1 | Write strobe into the video transmit buffer |
| buf_wdata | output | WORD_W | Packed data word |
| buf_waddr | output | clog2(ROW_PIX·PIX_W/WORD_W) | Word address within the packet |
| send_req | output | 1 | One-cycle request to transmit the packet |
| hdr_row | output | clog2(ROWS) | Row identifier of the packet |
| hdr_col | output | clog2(ROW_PIX) | Column identifier of the first pixel |

## Verification
A wrong bit-fill count in the packer shows up in `buf_wdata` on the very next write, within six accepted pixels. A wrong word counter shows up in `buf_waddr` on that same strobe. A corrupted row counter or ordering mode stays hidden until the next `send_req`, where `hdr_row` differs, so each ordering is run across a wrap of the frame. A control state that is off by a cycle moves `pix_ready` or `send_req` in that same cycle. All outputs are compared every clock against a behavioural model, so such a slip is reported where it happens.

// File: rtl/video_row_packer.sv
module video_row_packer #(
  parameter int PIX_W   = 12,
  parameter int ROW_PIX = 2048,
  parameter int ROWS    = 1024,
  parameter int WORD_W  = 64
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      split_rd,
  input  logic                                      link_free,
  input  logic                                      pix_valid,
  input  logic                                      pix_sof,
  input  logic                                      pix_sol,
  input  logic [PIX_W-1:0]                          pix_data,
  output logic                                      pix_ready,
  output logic                                      buf_we,
  output logic [WORD_W-1:0]                         buf_wdata,
  output logic [$clog2(ROW_PIX*PIX_W/WORD_W)-1:0]   buf_waddr,
  output logic                                      send_req,
  output logic [$clog2(ROWS)-1:0]                   hdr_row,
  output logic [$clog2(ROW_PIX)-1:0]                hdr_col
);
  localparam int WORDS = ROW_PIX * PIX_W / WORD_W;
  localparam int AW = $clog2(WORDS);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(ROW_PIX);
  localparam int FW = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {S_RUN, S_FLUSH, S_SEND, S_WAIT} st_t;
  st_t st;

  logic [WORD_W-1:0]       acc, base;
  logic [FW-1:0]           fill, base_fill;
  logic [CW-1:0]           pcnt, idx;
  logic [AW-1:0]           wcnt, wbase;
  logic [RW-1:0]           rcnt, ridx, rid;
  logic                    split_q, split_now, take, first, wrap;
  logic [WORD_W+PIX_W-1:0] merged;

  assign pix_ready = (st == S_RUN);
  assign send_req  = (st == S_SEND);
  assign hdr_col   = '0;
  assign take      = pix_valid & pix_ready;
  assign first     = pix_sof | pix_sol | (pcnt == '0);
  assign base      = first ? '0 : acc;
  assign base_fill = first ? '0 : fill;
  assign idx       = first ? '0 : pcnt;
  assign wbase     = first ? '0 : wcnt;
  assign merged    = {{PIX_W{1'b0}}, base} | ({{WORD_W{1'b0}}, pix_data} << base_fill);
  assign wrap      = (int'(base_fill) + PIX_W) >= WORD_W;
  assign ridx      = pix_sof ? '0 : rcnt;
  assign split_now = pix_sof ? split_rd : split_q;
  assign rid       = !split_now ? ridx
                   : ridx[0] ? (RW'(ROWS - 1) - (ridx >> 1)) : (ridx >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      acc       <= '0;
      fill      <= '0;
      pcnt      <= '0;
      wcnt      <= '0;
      rcnt      <= '0;
      split_q   <= 1'b0;
      buf_we    <= 1'b0;
      buf_wdata <= '0;
      buf_waddr <= '0;
      hdr_row   <= '0;
    end else begin
      buf_we <= 1'b0;
      case (st)
        S_RUN: if (take) begin
          if (first) begin
            hdr_row <= rid;
            rcnt    <= ridx;
            if (pix_sof) split_q <= split_rd;
          end
          if (wrap) begin
            buf_we    <= 1'b1;
            buf_wdata <= merged[WORD_W-1:0];
            buf_waddr <= wbase;
            wcnt      <= wbase + AW'(1);
            acc       <= {{(WORD_W-PIX_W){1'b0}}, merged[WORD_W +: PIX_W]};
            fill      <= FW'(int'(base_fill) + PIX_W - WORD_W);
          end else begin
            wcnt <= wbase;
            acc  <= merged[WORD_W-1:0];
            fill <= FW'(int'(base_fill) + PIX_W);
          end
          if (idx == CW'(ROW_PIX - 1)) begin
            pcnt <= '0;
            st   <= S_FLUSH;
          end else begin
            pcnt <= CW'(int'(idx) + 1);
          end
        end
        S_FLUSH: st <= S_SEND;
        S_SEND: begin
          st   <= S_WAIT;
          rcnt <= (rcnt == RW'(ROWS - 1)) ? '0 : rcnt + RW'(1);
        end
        S_WAIT: if (link_free) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  p_send_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |=> !send_req);
  p_send_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> $past(buf_we));
  p_last_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> $past(buf_waddr) == AW'(WORDS - 1));
  p_hold_during_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> !pix_ready);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_ready) |-> $past(link_free));
  p_write_from_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(pix_valid) && $past(pix_ready));
  p_row_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> int'(hdr_row) < ROWS);
endmodule

// File: tb/video_row_packer_test.sv
module video_row_packer_test;
  localparam int RP = 32;
  localparam int NR = 6;

  logic clk = 0, rst_n = 0;
  logic split_rd = 0, link_free = 1, pix_valid = 0, pix_sof = 0, pix_sol = 0;
  logic [11:0] pix_data = '0;
  logic pix_ready, buf_we, send_req;
  logic [63:0] buf_wdata;
  logic [2:0] buf_waddr, hdr_row;
  logic [4:0] hdr_col;

  video_row_packer #(.ROW_PIX(RP), .ROWS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .split_rd(split_rd), .link_free(link_free),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_data(pix_data),
    .pix_ready(pix_ready), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_waddr(buf_waddr),
    .send_req(send_req), .hdr_row(hdr_row), .hdr_col(hdr_col));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, seed = 1;
  string scen = "R10 reset";
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference
  bit bq[$];
  int m_ph = 0, m_pcnt = 0, m_k = 0, m_waddr = 0;
  bit m_split = 0, m_rsplit = 0;
  bit e_ready = 1, e_we = 0, e_send = 0;
  logic [63:0] e_data = '0;
  int e_addr = 0, e_row = 0;

  function automatic int map_row(int k, bit s);
    if (!s) return k;
    return (k % 2) ? NR - 1 - k / 2 : k / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete(); m_ph = 0; m_pcnt = 0; m_k = 0; m_waddr = 0; m_split = 0;
      e_ready = 1; e_we = 0; e_send = 0;
    end else begin
      e_we = 0; e_send = 0;
      case (m_ph)
        0: if (pix_valid && e_ready) begin
          if (pix_sof || pix_sol || m_pcnt == 0) begin
            bq.delete(); m_waddr = 0; m_pcnt = 0;
            if (pix_sof) begin m_k = 0; m_split = split_rd; end
            e_row = map_row(m_k, m_split); m_rsplit = m_split;
          end
          for (int b = 0; b < 12; b++) bq.push_back(pix_data[b]);
          m_pcnt++;
          if (bq.size() >= 64) begin
            for (int b = 0; b < 64; b++) e_data[b] = bq.pop_front();
            e_we = 1; e_addr = m_waddr; m_waddr++;
          end
          if (m_pcnt == RP) begin m_pcnt = 0; m_ph = 1; e_ready = 0; end
        end
        1: begin m_ph = 2; e_send = 1; end
        2: begin m_ph = 3; m_k = (m_k + 1) % NR; end
        default: if (link_free) begin m_ph = 0; e_ready = 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    chk(pix_ready === e_ready, (!rst_n) ? "R10 ready" : "R7 ready", 64'(pix_ready), 64'(e_ready));
    chk(buf_we === e_we, (!rst_n) ? "R10 we" : "R2 we", 64'(buf_we), 64'(e_we));
    chk(send_req === e_send, (!rst_n) ? "R10 send" : "R3 send", 64'(send_req), 64'(e_send));
    if (e_we && buf_we) begin
      chk(buf_wdata === e_data, "R1 data", buf_wdata, e_data);
      chk(int'(buf_waddr) == e_addr, "R2 addr", 64'(buf_waddr), 64'(e_addr));
    end
    if (e_send && send_req) begin
      chk(int'(hdr_row) == e_row, m_rsplit ? "R6 row" : "R5 row", 64'(hdr_row), 64'(e_row));
      chk(hdr_col === '0, "R4 col", 64'(hdr_col), 64'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_sim();
    end
  end

  task automatic put(input bit sol, input bit sof);
    bit r;
    seed = seed * 1103515245 + 12345;
    pix_valid = 1; pix_data = 12'(seed >>> 7); pix_sol = sol; pix_sof = sof;
    forever begin
      r = pix_ready;
      @(negedge clk);
      if (r) break;
    end
    pix_valid = 0; pix_sol = 0; pix_sof = 0;
  endtask

  task automatic row(input int n, input int mark, input bit gaps);
    for (int i = 0; i < n; i++) begin
      put(i == 0 && mark >= 1, i == 0 && mark == 2);
      if (gaps && i % 5 == 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    scen = "R5 normal frame with wrap, R11 valid held while busy";
    split_rd = 0;
    row(RP, 2, 0);
    split_rd = 1;
    for (int r = 1; r < NR + 2; r++) row(RP, (r % 2) ? 1 : 0, 0);
    scen = "R6 interleaved frame with wrap, R8 mode latched at sof";
    split_rd = 1;
    row(RP, 2, 1);
    split_rd = 0;
    for (int r = 1; r < NR + 2; r++) row(RP, 1, r == 3);
    scen = "R8 sof mid-frame restarts row count in normal order";
    split_rd = 0;
    row(RP, 2, 0);
    row(RP, 1, 0);
    scen = "R9 sol restarts a partial row";
    row(10, 1, 0);
    row(RP, 1, 0);
    row(7, 0, 0);
    row(RP, 2, 0);
    scen = "R7 link busy holds ready low, R11 valid ignored";
    link_free = 0;
    fork
      row(RP, 1, 0);
      begin
        @(posedge send_req);
        repeat (15) @(negedge clk);
        link_free = 1;
      end
    join
    row(RP, 1, 1);
    repeat (10) @(negedge clk);
    finish_sim();
  end
endmodule